// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for each beat of a four-beat burst. A load captures a full external address and starts a burst. Each later advance moves a two-bit beat counter on by one. The beat counter changes only the two lowest address bits, so the upper bits stay at the loaded value for the whole burst. After four beats the sequence wraps inside the same four-word group.

A single control input chooses between loading and advancing. A load that arrives while the chip-select-valid input is low does not start a burst; it cancels any burst in progress, and the current address stays as it was. A clock enable freezes every register while it is low. The order input picks the beat order. Linear order adds the beat count to the starting low bits, modulo 4. Interleaved order XORs the starting low bits with the beat count. The order input is applied combinationally to the stored start and beat count, so the block holds no state for it.

Top module: `burst_addr_seq`

## Requirements
- R1: While reset is asserted, and after it is released until the first load, `cur_addr` is 0 and `burst_active` is 0.
- R2: When `clk_en`=1, `advance`=0 and `chip_sel`=1 at a rising edge, `cur_addr` equals `ext_addr` after that edge and `burst_active` is 1. This also holds while a burst is already running, and it restarts the beat count at 0.
- R3: Advances never change `cur_addr[ADDR_W-1:2]`; those bits keep the loaded value.
- R4: With `order_ilv`=0, after k advances of an active burst, `cur_addr[1:0]` = (start + k) mod 4, where start is the loaded `ext_addr[1:0]`.
- R5: With `order_ilv`=1, after k advances of an active burst, `cur_addr[1:0]` = start XOR (k mod 4).
- R6: The beat count wraps after the fourth beat. A fifth and sixth advance repeat the first and second beats of the same four-word group.
- R7: When `clk_en`=1, `advance`=0 and `chip_sel`=0 at a rising edge, `burst_active` is 0 after that edge and `cur_addr` is unchanged.
- R8: At an edge where `clk_en`=0, neither `cur_addr` nor `burst_active` changes, whatever `advance`, `chip_sel` and `ext_addr` are.
- R9: When `advance`=1 while `burst_active`=0, `cur_addr` does not change.
- R10: `order_ilv` acts combinationally. Changing it with no clock edge changes `cur_addr[1:0]` from the linear value to the interleaved value for the same beat count, or back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | 1 = registers update at the edge; 0 = everything holds |
| advance | input | 1 | 0 = load (or cancel when deselected), 1 = step the beat counter |
| chip_sel | input | 1 | 1 = a load is valid; 0 = a load cancels the burst |
| order_ilv | input | 1 | 0 = linear beat order, 1 = interleaved beat order |
| ext_addr | input | ADDR_W | External start address captured on a valid load |
| cur_addr | output | ADDR_W | Address of the current beat |
| burst_active | output | 1 | 1 while a burst is in progress |

## Verification
Clock suspension and the load/cancel decision can land on the same edge. Likewise, a new load can arrive in the middle of a running burst. The bench provokes the first by presenting a deselect or a fresh address while `clk_en` is low, and then checks that the address and the flag are frozen. It provokes the second by reloading and by deselecting two beats into a burst, and then checks that the restart sets the beat count back to zero and that the cancel leaves the address where it stood. Every start value is swept in both orders through six beats, and each result is compared with the modulo sum or the XOR computed in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  localparam int BEAT_W = 2;
  typedef logic [BEAT_W-1:0] beat_t;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } order_e;

  // Linear order: beat count added to start, wrapping within the group.
  function automatic beat_t lin_beat(beat_t start, beat_t cnt);
    return beat_t'(start + cnt);
  endfunction

  // Interleaved order: start XORed with the beat count.
  function automatic beat_t ilv_beat(beat_t start, beat_t cnt);
    return start ^ cnt;
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr
  import burst_seq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  step,
  output beat_t beat
);
  // Named event: the counter rolls over from the last beat to the first.
  logic wrap_evt;
  assign wrap_evt = step && !restart && (beat == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat <= '0;
    else if (restart) beat <= '0;
    else if (step)    beat <= beat_t'(beat + 1'b1);
  end

  // R6: after the last beat the count returns to zero
  a_r6_beat_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (beat == '0));
  // R2: a restart always begins at beat zero
  a_r2_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (beat == '0));
  // R8 / R9: no step and no restart means the count holds
  a_r8_beat_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !restart) |=> $stable(beat));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [ADDR_W-1:0] d,
  output logic [ADDR_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (capture) q <= d;
  end

  // R2: a capture stores the presented address
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (q == $past(d)));
  // R3 / R8: without a capture the stored address never moves
  a_r3_base_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(q));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter bit ALLOW_ILV = 1'b1
) (
  input  beat_t start,
  input  beat_t beat,
  input  logic  order_ilv,
  output beat_t lo
);
  beat_t lin_lo;
  assign lin_lo = lin_beat(start, beat);

  generate
    if (ALLOW_ILV) begin : g_both
      beat_t ilv_lo;
      assign ilv_lo = ilv_beat(start, beat);
      assign lo = (order_e'(order_ilv) == ORD_INTERLEAVE) ? ilv_lo : lin_lo;
    end else begin : g_lin_only
      logic unused_sel;
      assign unused_sel = order_ilv;
      assign lo = lin_lo;
    end
  endgenerate

  // R4 / R5: beat zero always reproduces the start value in either order
  always_comb begin
    a_r4_beat0_start: assert (!(beat == '0) || (lo == start));
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter bit ALLOW_ILV = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              advance,
  input  logic              chip_sel,
  input  logic              order_ilv,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] cur_addr,
  output logic              burst_active
);
  localparam int HI_W = ADDR_W - BEAT_W;

  // Named internal events
  logic load_req, load_ok, cancel_evt, step_ok, idle_adv;
  assign load_req   = clk_en && !advance;
  assign load_ok    = load_req && chip_sel;
  assign cancel_evt = load_req && !chip_sel;
  assign step_ok    = clk_en && advance && burst_active;
  assign idle_adv   = clk_en && advance && !burst_active;

  logic [ADDR_W-1:0] base_q;
  beat_t             beat_q;
  beat_t             lo_bits;

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .capture (load_ok),
    .d       (ext_addr),
    .q       (base_q)
  );

  burst_beat_ctr u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (load_ok),
    .step    (step_ok),
    .beat    (beat_q)
  );

  burst_order_map #(.ALLOW_ILV(ALLOW_ILV)) u_map (
    .start     (base_q[BEAT_W-1:0]),
    .beat      (beat_q),
    .order_ilv (order_ilv),
    .lo        (lo_bits)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          burst_active <= 1'b0;
    else if (load_ok)    burst_active <= 1'b1;
    else if (cancel_evt) burst_active <= 1'b0;
  end

  assign cur_addr = {base_q[ADDR_W-1:BEAT_W], lo_bits};

  // R1: reset clears the outputs
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!burst_active && cur_addr == '0));
  // R2: a valid load is visible at the port on the next cycle
  a_r2_load_visible: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |=> (burst_active && cur_addr == $past(ext_addr)));
  // R3: stepping keeps the upper bits
  a_r3_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    step_ok |=> (cur_addr[ADDR_W-1:BEAT_W] == $past(cur_addr[ADDR_W-1:BEAT_W])));
  // R4: linear steps move the low bits by one, modulo 4
  a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step_ok && !order_ilv) |=>
      (order_ilv || cur_addr[BEAT_W-1:0] == beat_t'($past(cur_addr[BEAT_W-1:0]) + 1'b1)));
  // R7: a deselected load drops the flag and keeps the address
  a_r7_cancel: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_evt |=> (!burst_active && $stable(base_q) && $stable(beat_q)));
  // R8: a suspended clock freezes the flag
  a_r8_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(burst_active) && $stable(base_q) && $stable(beat_q)));
  // R9: an advance while idle leaves the state alone
  a_r9_idle_adv: assert property (@(posedge clk) disable iff (!rst_n)
    idle_adv |=> ($stable(base_q) && $stable(beat_q) && !burst_active));
  // R3: the upper field has a fixed width
  if (HI_W < 1) begin : g_bad_width
    initial a_r3_width_ok: assert (HI_W >= 1);
  end
endmodule

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          advance = 1'b0;
  logic          chip_sel = 1'b0;
  logic          order_ilv = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] cur_addr;
  logic          burst_active;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .advance(advance),
    .chip_sel(chip_sel), .order_ilv(order_ilv), .ext_addr(ext_addr),
    .cur_addr(cur_addr), .burst_active(burst_active)
  );

  function automatic logic [AW-1:0] expect_addr(logic [AW-1:0] base, int k, logic ilv);
    int s;
    int lo;
    s  = int'(base) % 4;
    lo = ilv ? (s ^ (k % 4)) : ((s + k) % 4);
    return AW'((int'(base) / 4) * 4 + lo);
  endfunction

  task automatic chk(string req, logic [AW-1:0] a_exp, logic act_exp);
    checks++;
    if (cur_addr !== a_exp || burst_active !== act_exp) begin
      fails++;
      $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
               req, cur_addr, burst_active, a_exp, act_exp);
    end
  endtask

  task automatic cyc(logic en, logic adv, logic cs, logic [AW-1:0] a);
    @(negedge clk);
    clk_en = en; advance = adv; chip_sel = cs; ext_addr = a;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(20 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [AW-1:0] uppers [3];
    logic [AW-1:0] b;
    uppers[0] = 8'h00; uppers[1] = 8'hA4; uppers[2] = 8'hFC;

    // R1: reset state
    repeat (2) @(posedge clk);
    #1 chk("R1 in reset", '0, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    cyc(1'b1, 1'b1, 1'b1, 8'h77);
    chk("R1 after release", '0, 1'b0);

    // R2..R6: sweep starts and orders
    for (int u = 0; u < 3; u++) begin
      for (int m = 0; m < 2; m++) begin
        for (int s = 0; s < 4; s++) begin
          b = uppers[u] | AW'(s);
          order_ilv = m[0];
          cyc(1'b1, 1'b0, 1'b1, b);
          chk("R2 load", b, 1'b1);
          for (int k = 1; k <= 6; k++) begin
            cyc(1'b1, 1'b1, 1'b1, ~b);
            if (k >= 4)
              chk("R6 wrap", expect_addr(b, k, m[0]), 1'b1);
            else if (m == 1)
              chk("R5 interleaved R3", expect_addr(b, k, 1'b1), 1'b1);
            else
              chk("R4 linear R3", expect_addr(b, k, 1'b0), 1'b1);
          end
        end
      end
    end

    // R7 / R9: deselect mid-burst, then idle advance
    order_ilv = 1'b0;
    cyc(1'b1, 1'b0, 1'b1, 8'h5B);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    chk("R4 pre-cancel", 8'h59, 1'b1);
    cyc(1'b1, 1'b0, 1'b0, 8'h11);
    chk("R7 cancel", 8'h59, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 8'h22);
    chk("R9 idle advance", 8'h59, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 8'h33);
    chk("R7 cancel while idle", 8'h59, 1'b0);

    // R8: suspended clock with load, deselect, advance
    cyc(1'b1, 1'b0, 1'b1, 8'h32);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    chk("R4 pre-suspend", 8'h33, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 8'hFF);
    chk("R8 load suspended", 8'h33, 1'b1);
    cyc(1'b0, 1'b0, 1'b0, 8'hFF);
    chk("R8 deselect suspended", 8'h33, 1'b1);
    cyc(1'b0, 1'b1, 1'b1, 8'hFF);
    chk("R8 advance suspended", 8'h33, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 8'hFF);
    chk("R8 resume", 8'h30, 1'b1);

    // R2: reload mid-burst restarts at beat 0
    cyc(1'b1, 1'b0, 1'b1, 8'h40);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    cyc(1'b1, 1'b0, 1'b1, 8'h87);
    chk("R2 reload", 8'h87, 1'b1);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    chk("R4 after reload", 8'h84, 1'b1);

    // R10: order switch without a clock edge
    cyc(1'b1, 1'b0, 1'b1, 8'h21);
    cyc(1'b1, 1'b1, 1'b1, 8'h00);
    chk("R10 linear beat1", 8'h22, 1'b1);
    @(negedge clk) order_ilv = 1'b1;
    #1 chk("R10 interleaved beat1", 8'h20, 1'b1);
    order_ilv = 1'b0;
    #1 chk("R10 back to linear", 8'h22, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule